// File: doc/BRIEF.md
# SPI Burst Master with Auto-Transmit

This block is a synchronous serial master. Frames queued in a small transmit buffer are shifted out on MOSI, most significant bit first, on a serial clock that the block generates itself. MISO is captured on the same clock into a receive buffer. The serial clock runs only while a frame is in flight. When there is no more work, it parks low.

An automatic chip select can frame each burst of back-to-back frames, with a selectable active level. In auto-transmit mode the block keeps clocking filler frames whenever the receive buffer has a free entry, so a host can read a long stream without queuing dummy words. A filler frame repeats the last bit driven on MOSI for every bit, and a sticky underflow flag records that such a frame went out. The chip-select pin can be turned into an input instead. Another master that drives it to the active level raises a sticky select flag and can, when allowed, push this block into slave mode, which stops all bus activity.

Top module: `spi_burst_master`

## Requirements
- R1: After reset: sclk is 0, mosi is 0, cs_o is at its inactive level, tx_ready is 1, rx_valid is 0, flags is 0 and slave_mode is 0.
- R2: A frame is FRAME_W bits sent MSB first. Each sclk half period lasts CLK_DIV clock cycles. mosi takes a frame's first bit in the cycle the frame is loaded, with sclk low, and afterwards changes only at falling sclk edges.
- R3: miso is sampled at each rising sclk edge. The FRAME_W samples, first sample in the MSB, are written to the receive buffer at the last rising edge of the frame. They are read in order through rx_data/rx_valid/rx_ready.
- R4: sclk toggles only while a frame is in flight. When no further frame may start, sclk stays low after the final falling edge. When the next frame may start, it is loaded at that same falling edge, with no idle cycle.
- R5: With auto_cs set and cs_is_input clear, cs_o is at its active level from a frame's load cycle through its final falling edge, and it stays active across back-to-back frames. The active level is 0 when cs_invert is 0 and 1 when cs_invert is 1. cs_oe equals the inverse of cs_is_input.
- R6: A frame starts only when the receive buffer has a free entry. If the receive buffer is full, the clock pauses low at the frame boundary and resumes once an entry is read.
- R7: With auto_tx set and the transmit buffer empty, a filler frame is sent. Every bit of a filler frame equals the last bit previously driven on mosi.
- R8: The start of a filler frame sets flags[0] (underflow), which stays set until cleared.
- R9: With cs_is_input set, a cs_i level equal to cs_invert, seen after a CS_SYNC-flop synchronizer, sets flags[1] (select seen). If takeover is also set, slave_mode becomes 1 and no frame starts or continues. slave_mode returns to 0 when en is 0.
- R10: A 1 on flag_clr[i] clears flags[i] at the next edge, unless the same flag is set in that cycle. Setting wins.
- R11: The transmit buffer holds TX_DEPTH frames, and tx_ready is 0 while it is full. Frames go out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable; when low, the block stops and leaves slave mode |
| auto_cs | input | 1 | Drive cs_o automatically around bursts |
| cs_invert | input | 1 | Selects an active-high chip select |
| cs_is_input | input | 1 | Use the CS pin as an input (cs_oe low) |
| takeover | input | 1 | Allow an active CS input to force slave mode |
| auto_tx | input | 1 | Send filler frames when the transmit buffer is empty |
| tx_data | input | FRAME_W | Frame to queue |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Transmit buffer has room |
| rx_data | output | FRAME_W | Oldest received frame |
| rx_valid | output | 1 | Receive buffer is not empty |
| rx_ready | input | 1 | Host takes rx_data |
| flag_clr | input | 2 | Write-one-to-clear strobes for flags |
| flags | output | 2 | Sticky flags: bit 0 underflow, bit 1 select seen |
| slave_mode | output | 1 | Bus given up to another master |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select output value |
| cs_oe | output | 1 | Chip select output enable |
| cs_i | input | 1 | Chip select pin value when used as input |

## Verification
The properties assume that control inputs change only between frames or at a point the block tolerates. They also assume that miso and the control bits are synchronous to clk, while cs_i may be asynchronous because it passes through the synchronizer. The bench drives every input a short delay after the rising edge and changes miso only at rising edges, so each sample sees a settled value. The bench enables takeover only after the other controls are already set, and it drops en only after slave mode has been reached.

// File: rtl/spi_am_pkg.sv
package spi_am_pkg;

   localparam int FLAG_N  = 2;
   localparam int FLAG_UF = 0;
   localparam int FLAG_SS = 1;

   typedef enum logic [0:0] {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

endpackage

// File: rtl/spi_am_fifo.sv
module spi_am_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);

   generate
      if (DEPTH == 1) begin : g_single
         logic         vld_q;
         logic [W-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else if (wr_en && !vld_q) begin
               vld_q <= 1'b1;
               dat_q <= wr_data;
            end else if (rd_en && vld_q) begin
               vld_q <= 1'b0;
            end
         end
         assign rd_data = dat_q;
         assign full    = vld_q;
         assign empty   = !vld_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);
         localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
         localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wr_q, rd_q;
         logic [CNT_W-1:0] cnt_q;
         logic             do_wr, do_rd;

         assign full  = (cnt_q == CNT_FULL);
         assign empty = (cnt_q == '0);
         assign do_wr = wr_en && !full;
         assign do_rd = rd_en && !empty;

         always_ff @(posedge clk) begin
            if (do_wr) mem[wr_q] <= wr_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q  <= '0;
               rd_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_wr) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
               if (do_rd) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
               if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
               else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
            end
         end

         assign rd_data = mem[rd_q];
      end
   endgenerate

endmodule

// File: rtl/spi_am_engine.sv
module spi_am_engine
   import spi_am_pkg::*;
#(
   parameter int FRAME_W = 8,
   parameter int CLK_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt,
   input  logic               may_start,
   input  logic               auto_tx,
   input  logic               tx_avail,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic               miso,
   output logic               tx_pop,
   output logic               fill_start,
   output logic               rx_push,
   output logic [FRAME_W-1:0] rx_word,
   output logic               busy,
   output logic               sclk,
   output logic               mosi
);

   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BIT_W = $clog2(FRAME_W);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

   eng_state_e         st_q;
   logic               sclk_q;
   logic [DIV_W-1:0]   div_q;
   logic [BIT_W-1:0]   bit_q;
   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] rxsh_q;

   logic run, half, rise, fall, last, want, load;

   assign run  = (st_q == ENG_RUN);
   assign half = run && (div_q == DIV_LAST);
   assign rise = half && !sclk_q;
   assign fall = half && sclk_q;
   assign last = (bit_q == BIT_LAST);
   assign want = may_start && (tx_avail || auto_tx);
   assign load = !halt && want && (!run || (fall && last));

   assign tx_pop     = load && tx_avail;
   assign fill_start = load && !tx_avail;
   assign rx_push    = !halt && rise && last;
   assign rx_word    = {rxsh_q[FRAME_W-2:0], miso};

   assign busy = run;
   assign sclk = sclk_q;
   assign mosi = sh_q[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         sclk_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         rxsh_q <= '0;
      end else if (halt) begin
         st_q   <= ENG_IDLE;
         sclk_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
      end else if (load) begin
         st_q   <= ENG_RUN;
         sclk_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         sh_q   <= tx_avail ? tx_word : {FRAME_W{sh_q[FRAME_W-1]}};
      end else if (run) begin
         div_q <= half ? '0 : div_q + 1'b1;
         if (half) sclk_q <= !sclk_q;
         if (rise) rxsh_q <= {rxsh_q[FRAME_W-2:0], miso};
         if (fall) begin
            if (last) begin
               st_q <= ENG_IDLE;
            end else begin
               bit_q <= bit_q + 1'b1;
               sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

endmodule

// File: rtl/spi_am_cs.sv
module spi_am_cs #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic auto_cs,
   input  logic cs_invert,
   input  logic cs_is_input,
   input  logic takeover,
   input  logic busy,
   input  logic cs_i,
   output logic cs_o,
   output logic cs_oe,
   output logic sel_seen,
   output logic slave_mode
);

   logic [SYNC-1:0] chain_q;
   logic            cs_sync;
   logic            sel_active;
   logic            drive_sel;
   logic            slave_q;

   generate
      if (SYNC == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= cs_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC-2:0], cs_i};
         end
      end
   endgenerate

   assign cs_sync    = chain_q[SYNC-1];
   assign sel_active = cs_is_input && (cs_sync == cs_invert);
   assign sel_seen   = sel_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      slave_q <= 1'b0;
      else if (!en)                    slave_q <= 1'b0;
      else if (sel_active && takeover) slave_q <= 1'b1;
   end

   assign slave_mode = slave_q;
   assign drive_sel  = auto_cs && busy && !cs_is_input;
   assign cs_o       = drive_sel ? cs_invert : !cs_invert;
   assign cs_oe      = !cs_is_input;

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_am_pkg::*;
#(
   parameter int FRAME_W  = 8,
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 4,
   parameter int CLK_DIV  = 2,
   parameter int CS_SYNC  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               auto_cs,
   input  logic               cs_invert,
   input  logic               cs_is_input,
   input  logic               takeover,
   input  logic               auto_tx,
   input  logic [FRAME_W-1:0] tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic [FRAME_W-1:0] rx_data,
   output logic               rx_valid,
   input  logic               rx_ready,
   input  logic [FLAG_N-1:0]  flag_clr,
   output logic [FLAG_N-1:0]  flags,
   output logic               slave_mode,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic               cs_o,
   output logic               cs_oe,
   input  logic               cs_i
);

   generate
      if (FRAME_W < 4 || FRAME_W > 16) begin : g_bad_frame
         $error("spi_burst_master: FRAME_W must lie in 4..16");
      end
      if (TX_DEPTH < 1 || RX_DEPTH < 1) begin : g_bad_depth
         $error("spi_burst_master: buffer depths must be at least 1");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("spi_burst_master: CLK_DIV must be at least 1");
      end
      if (CS_SYNC < 1) begin : g_bad_sync
         $error("spi_burst_master: CS_SYNC must be at least 1");
      end
   endgenerate

   logic               tx_full, tx_empty, tx_pop;
   logic [FRAME_W-1:0] tx_word;
   logic               rx_full, rx_empty, rx_push;
   logic [FRAME_W-1:0] rx_word;
   logic               eng_busy, fill_start, sel_seen;
   logic               halt, may_start;
   logic [FLAG_N-1:0]  flag_set, flags_q;

   assign halt      = !en || slave_mode;
   assign may_start = en && !slave_mode && !rx_full;
   assign tx_ready  = !tx_full;
   assign rx_valid  = !rx_empty;

   spi_am_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tx_valid),
      .wr_data (tx_data),
      .rd_en   (tx_pop),
      .rd_data (tx_word),
      .full    (tx_full),
      .empty   (tx_empty)
   );

   spi_am_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rx_push),
      .wr_data (rx_word),
      .rd_en   (rx_ready),
      .rd_data (rx_data),
      .full    (rx_full),
      .empty   (rx_empty)
   );

   spi_am_engine #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (halt),
      .may_start  (may_start),
      .auto_tx    (auto_tx),
      .tx_avail   (!tx_empty),
      .tx_word    (tx_word),
      .miso       (miso),
      .tx_pop     (tx_pop),
      .fill_start (fill_start),
      .rx_push    (rx_push),
      .rx_word    (rx_word),
      .busy       (eng_busy),
      .sclk       (sclk),
      .mosi       (mosi)
   );

   spi_am_cs #(.SYNC(CS_SYNC)) u_cs (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .auto_cs     (auto_cs),
      .cs_invert   (cs_invert),
      .cs_is_input (cs_is_input),
      .takeover    (takeover),
      .busy        (eng_busy),
      .cs_i        (cs_i),
      .cs_o        (cs_o),
      .cs_oe       (cs_oe),
      .sel_seen    (sel_seen),
      .slave_mode  (slave_mode)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[FLAG_UF] = fill_start;
      flag_set[FLAG_SS] = sel_seen;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flag_set | (flags_q & ~flag_clr);
   end

   assign flags = flags_q;

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sclk,
   input logic       mosi,
   input logic       cs_o,
   input logic       auto_cs,
   input logic       cs_invert,
   input logic       cs_is_input,
   input logic       eng_busy,
   input logic       rx_push,
   input logic       rx_full,
   input logic       slave_mode,
   input logic       fill_start,
   input logic [1:0] flags,
   input logic [1:0] flag_clr
);

   // R4: clock parked low whenever no frame is in flight
   p_sclk_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !sclk);

   // R2: data held steady through the high phase of sclk
   p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R5: chip select at its active level while a frame runs
   p_cs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_cs && !cs_is_input && eng_busy) |-> (cs_o == cs_invert));

   // R6: a received frame never meets a full buffer
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full);

   // R9: slave mode stops the engine
   p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |=> !eng_busy);

   // R8: filler frame raises underflow
   p_fill_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_start |=> flags[0]);

   // R10: underflow stays until cleared
   p_uf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !flag_clr[0]) |=> flags[0]);

endmodule

bind spi_burst_master spi_burst_master_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk        (sclk),
   .mosi        (mosi),
   .cs_o        (cs_o),
   .auto_cs     (auto_cs),
   .cs_invert   (cs_invert),
   .cs_is_input (cs_is_input),
   .eng_busy    (eng_busy),
   .rx_push     (rx_push),
   .rx_full     (rx_full),
   .slave_mode  (slave_mode),
   .fill_start  (fill_start),
   .flags       (flags),
   .flag_clr    (flag_clr)
);

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;

   localparam int FW  = 8;
   localparam int TXD = 4;
   localparam int RXD = 2;
   localparam int DIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 0, auto_cs = 0, cs_invert = 0, cs_is_input = 0, takeover = 0, auto_tx = 0;
   logic [FW-1:0] tx_data = '0;
   logic tx_valid = 0, rx_ready = 0;
   logic [1:0] flag_clr = '0;
   logic miso = 0, cs_i = 1;
   logic tx_ready, rx_valid, slave_mode, sclk, mosi, cs_o, cs_oe;
   logic [FW-1:0] rx_data;
   logic [1:0] flags;

   always #10 clk = ~clk;

   spi_burst_master #(.FRAME_W(FW), .TX_DEPTH(TXD), .RX_DEPTH(RXD), .CLK_DIV(DIV), .CS_SYNC(2))
   u_spi_burst_master (
      .clk(clk), .rst_n(rst_n), .en(en), .auto_cs(auto_cs), .cs_invert(cs_invert),
      .cs_is_input(cs_is_input), .takeover(takeover), .auto_tx(auto_tx),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .flag_clr(flag_clr), .flags(flags), .slave_mode(slave_mode),
      .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o), .cs_oe(cs_oe), .cs_i(cs_i)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 0;

   // behavioural reference model
   logic [FW-1:0] txq[$];
   logic [FW-1:0] rxq[$];
   bit m_busy = 0, m_sclk = 0, m_fill = 0, m_slave = 0, m_s1 = 1, m_s2 = 1;
   int m_div = 0, m_bit = 0;
   logic [FW-1:0] m_sh = '0, m_rxsh = '0;
   logic [1:0] m_flags = '0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      bit stop, want, edge_, rise, fall, last, load, have, act_in, push_rx, set_uf, set_ss;
      logic [FW-1:0] word, rword;
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_busy = 0; m_sclk = 0; m_fill = 0; m_slave = 0; m_s1 = 1; m_s2 = 1;
         m_div = 0; m_bit = 0; m_sh = '0; m_rxsh = '0; m_flags = '0;
      end else begin
         act_in = cs_is_input && (m_s2 == cs_invert);
         stop   = !en || m_slave;
         want   = en && !m_slave && (rxq.size() < RXD) && (txq.size() > 0 || auto_tx);
         edge_  = m_busy && (m_div == DIV - 1);
         rise   = edge_ && !m_sclk;
         fall   = edge_ && m_sclk;
         last   = (m_bit == FW - 1);
         load   = !stop && want && (!m_busy || (fall && last));
         have   = txq.size() > 0;
         push_rx = !stop && rise && last;
         rword  = {m_rxsh[FW-2:0], miso};
         set_uf = load && !have;
         set_ss = act_in;
         word   = have ? txq[0] : '0;
         // buffers
         if (load && have) void'(txq.pop_front());
         if (tx_valid && (txq.size() + ((load && have) ? 1 : 0)) < TXD) txq.push_back(tx_data);
         if (rx_ready && rxq.size() > 0) void'(rxq.pop_front());
         if (push_rx) rxq.push_back(rword);
         // flags and bus ownership
         m_flags[0] = set_uf | (m_flags[0] & !flag_clr[0]);
         m_flags[1] = set_ss | (m_flags[1] & !flag_clr[1]);
         m_slave = en ? (m_slave | (act_in && takeover)) : 1'b0;
         m_s2 = m_s1; m_s1 = cs_i;
         // serial engine
         if (stop) begin
            m_busy = 0; m_sclk = 0; m_div = 0; m_bit = 0;
         end else if (load) begin
            m_busy = 1; m_sclk = 0; m_div = 0; m_bit = 0; m_fill = !have;
            m_sh = have ? word : {FW{m_sh[FW-1]}};
         end else if (m_busy) begin
            m_div = edge_ ? 0 : m_div + 1;
            if (edge_) m_sclk = !m_sclk;
            if (rise) m_rxsh = rword;
            if (fall) begin
               if (last) m_busy = 0;
               else begin m_bit++; m_sh = {m_sh[FW-2:0], 1'b0}; end
            end
         end
      end
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      miso <= lfsr[15];
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         chk("R2 sclk", sclk, m_sclk);
         chk(m_fill ? "R7 mosi filler" : "R2 mosi", mosi, m_sh[FW-1]);
         chk("R5 cs_o", cs_o, (auto_cs && m_busy && !cs_is_input) ? cs_invert : !cs_invert);
         chk("R5 cs_oe", cs_oe, !cs_is_input);
         chk("R11 tx_ready", tx_ready, txq.size() < TXD);
         chk("R3 rx_valid", rx_valid, rxq.size() > 0);
         if (rxq.size() > 0) chk("R3 rx_data", rx_data, rxq[0]);
         chk("R8 flags[0]", flags[0], m_flags[0]);
         chk("R9 flags[1]", flags[1], m_flags[1]);
         chk("R9 slave_mode", slave_mode, m_slave);
      end
      if (cycles > 150000 && !done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic send(logic [FW-1:0] d);
      bit ok;
      tx_valid = 1; tx_data = d;
      do begin ok = tx_ready; tick(); end while (!ok);
      tx_valid = 0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while ((m_busy || txq.size() > 0) && guard < 5000) begin tick(); guard++; end
      tick(2);
   endtask

   task automatic count_rises(int n, output int rises);
      logic prev;
      rises = 0; prev = sclk;
      repeat (n) begin tick(); if (sclk && !prev) rises++; prev = sclk; end
   endtask

   initial begin
      int r;
      tick(4);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 sclk", sclk, 0);
      chk("R1 mosi", mosi, 0);
      chk("R1 cs_o", cs_o, 1);
      chk("R1 tx_ready", tx_ready, 1);
      chk("R1 rx_valid", rx_valid, 0);
      chk("R1 flags", flags, 0);
      chk("R1 slave_mode", slave_mode, 0);

      // back-to-back frames with automatic chip select (R2 R3 R4 R5 R11)
      en = 1; auto_cs = 1; rx_ready = 1;
      send(8'hA5); send(8'h3C); send(8'hF0); send(8'h0F); send(8'h96);
      wait_idle();
      chk("R4 sclk parked", sclk, 0);
      chk("R5 cs released", cs_o, 1);
      count_rises(12, r);
      chk("R4 no clock when idle", r, 0);

      // active-high chip select
      cs_invert = 1; tick();
      send(8'h5A);
      tick(3);
      chk("R5 cs active high", cs_o, 1);
      wait_idle();
      chk("R5 cs idle low", cs_o, 0);
      cs_invert = 0; tick();

      // receive buffer full stalls at frame boundary (R6)
      rx_ready = 0;
      send(8'h11); send(8'h22); send(8'h33); send(8'h44);
      repeat (200) begin if (rxq.size() == RXD && !m_busy) break; tick(); end
      count_rises(40, r);
      chk("R6 paused clock", r, 0);
      chk("R6 rx full valid", rx_valid, 1);
      rx_ready = 1;
      wait_idle();

      // auto-transmit after a word ending in 1 (R7 R8)
      rx_ready = 1; auto_tx = 1;
      send(8'h81);
      repeat (120) begin rx_ready = ~rx_ready; tick(); end
      flag_clr = 2'b01; tick(); flag_clr = 2'b00;
      rx_ready = 1;
      tick(60);
      auto_tx = 0;
      wait_idle();
      chk("R8 underflow sticky", flags[0], 1);
      flag_clr = 2'b01; tick(); flag_clr = 2'b00;
      chk("R10 underflow cleared", flags[0], 0);

      // auto-transmit after a word ending in 0 (R7)
      auto_tx = 1;
      send(8'h7E);
      tick(100);
      auto_tx = 0;
      wait_idle();
      flag_clr = 2'b11; tick(); flag_clr = 2'b00;
      chk("R10 clear both", flags, 0);

      // CS as input without takeover (R9)
      cs_is_input = 1; tick();
      cs_i = 0; tick(5);
      chk("R9 select seen", flags[1], 1);
      chk("R9 no takeover", slave_mode, 0);
      cs_i = 1; tick(4);
      flag_clr = 2'b10; tick(); flag_clr = 2'b00;
      chk("R10 select cleared", flags[1], 0);

      // takeover while traffic runs (R9)
      takeover = 1;
      send(8'hC3); send(8'h3C);
      tick(10);
      cs_i = 0; tick(6);
      chk("R9 slave entered", slave_mode, 1);
      count_rises(40, r);
      chk("R9 bus quiet", r, 0);
      cs_i = 1; en = 0; tick(2);
      chk("R9 slave left", slave_mode, 0);
      tick(5);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule